// File: doc/BRIEF.md
# Hot-Page Promotion and Stall Hint Unit

This unit sits in the controller of a memory-expansion device that keeps a DRAM cache in front of flash. It watches every access event that reaches the device, keeps a small saturating heat counter for each tracked page, and emits a promotion request for a page once its heat reaches a programmable threshold. The request tells the host both to copy the page into host memory and to update the page table. A per-page pending bit stops a page from being requested again until the host acknowledges it. A programmable epoch timer halves every counter at the end of each epoch, so heat that is not refreshed fades away.

For each access that misses in device DRAM and therefore goes to flash, the unit estimates how long the host would wait. The estimate is the remaining service time of the flash operations already outstanding plus the latency of the new read or write. The read latency, the write latency and the context-switch cost are all programmable cycle counts. When the estimate is larger than the switch cost, the unit raises a stall hint that carries the page and the estimate, so the host can switch context. Flash completion events retire outstanding operations in order.

Top module: `hp_promo_hint`

## Requirements
- R1: While `rst_n` is low and after its release, `promo_valid` and `hint_valid` are 0, every heat counter is 0, no page is pending and no flash operation is outstanding. The first miss after reset therefore has an estimate equal to its own latency.
- R2: Every access with `acc_valid`=1, hit or miss, adds one to the heat counter of `acc_page`. The counter saturates at 2^CNT_W-1 and does not wrap.
- R3: When an access leaves its page's counter at or above `cfg_hot_thresh` and the page is not pending, `promo_valid` is 1 in the next cycle with `promo_page` equal to that page. This single request covers both the copy and the page-table update.
- R4: A page stays pending from its promotion until `promo_ack`=1 with `promo_ack_page` equal to the page, and no further promotion is raised for it while pending. An acknowledge and an access to the same page in one cycle allow a new promotion in that cycle.
- R5: With `cfg_epoch_len`=L>0, every L-th cycle after reset release is a decay cycle in which all counters are shifted right by one. An access in a decay cycle increments the already halved value. L=0 disables decay.
- R6: For a miss (`acc_valid`=1, `acc_hit`=0) the estimate is the remaining time of the oldest outstanding operation, plus the latencies of the other outstanding operations, plus `cfg_wr_lat` if `acc_write`=1 or `cfg_rd_lat` otherwise. The estimate uses the state before that cycle. If it is strictly greater than `cfg_cs_cost`, `hint_valid` is 1 in the next cycle with `hint_page` and `hint_est` set.
- R7: An access with `acc_hit`=1 never raises a hint and adds no outstanding flash operation.
- R8: A miss queues its latency as an outstanding operation unless Q_DEPTH operations are already outstanding. In that case it is still estimated but not queued. The oldest operation's remaining time counts down by one per cycle to a floor of 0. `flash_done` retires the oldest operation, and the next one then starts at its full latency. `flash_done` with nothing outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hot_thresh | input | CNT_W | Heat level that marks a page hot |
| cfg_epoch_len | input | EPOCH_W | Cycles per decay epoch, 0 disables decay |
| cfg_rd_lat | input | LAT_W | Flash read latency in cycles |
| cfg_wr_lat | input | LAT_W | Flash write latency in cycles |
| cfg_cs_cost | input | LAT_W | Host context-switch cost in cycles |
| acc_valid | input | 1 | Access event strobe |
| acc_page | input | PAGE_W | Page index of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_hit | input | 1 | 1 when the access hit in device DRAM |
| flash_done | input | 1 | Oldest outstanding flash operation completed |
| promo_ack | input | 1 | Host acknowledges a promotion |
| promo_ack_page | input | PAGE_W | Page being acknowledged |
| promo_valid | output | 1 | Promotion (copy and page-table update) request |
| promo_page | output | PAGE_W | Page to promote |
| hint_valid | output | 1 | Stall hint to the host |
| hint_page | output | PAGE_W | Page whose access will stall |
| hint_est | output | EST_W | Estimated flash delay in cycles |

## Verification
The decay step and an access to the same page can fall in one cycle. The bench provokes this by counting cycles from reset release and placing an access on a page with heat 3 exactly on a decay cycle while the threshold is 4. The promotion must stay absent then and appear only after two further accesses. A flash completion and a new miss can also coincide. The bench drives both together while several operations are outstanding and judges the hint estimate, which must use the backlog from before the retirement, and the later estimates, which must reflect the next operation restarting at full latency.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  typedef enum logic {
    FOP_READ  = 1'b0,
    FOP_WRITE = 1'b1
  } flash_op_e;
endpackage

// File: rtl/hpm_heat.sv
module hpm_heat
  import hpm_pkg::*;
#(
  parameter  int NUM_PAGES = 16,
  parameter  int CNT_W     = 4,
  parameter  int EPOCH_W   = 16,
  localparam int PAGE_W    = $clog2(NUM_PAGES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_hot_thresh,
  input  logic [EPOCH_W-1:0] cfg_epoch_len,
  input  logic               acc_valid,
  input  logic [PAGE_W-1:0]  acc_page,
  input  logic               ack_valid,
  input  logic [PAGE_W-1:0]  ack_page,
  output logic               promo_valid,
  output logic [PAGE_W-1:0]  promo_page
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // epoch timer
  logic [EPOCH_W-1:0] ep_q, ep_d;
  logic               decay;

  always_comb begin
    decay = (cfg_epoch_len != '0) && (ep_q >= cfg_epoch_len - EPOCH_W'(1));
    if (cfg_epoch_len == '0 || decay) ep_d = '0;
    else                              ep_d = ep_q + EPOCH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ep_q <= '0;
    else        ep_q <= ep_d;
  end

  // promotion decision for the accessed page
  logic [CNT_W-1:0]     cnt_q [NUM_PAGES];
  logic [NUM_PAGES-1:0] pend_q, pend_d;
  logic [CNT_W-1:0]     sel_old, sel_base, sel_new;
  logic                 sel_ack, fire;

  always_comb begin
    sel_old  = cnt_q[acc_page];
    sel_base = decay ? (sel_old >> 1) : sel_old;
    sel_new  = (sel_base != CNT_MAX) ? sel_base + CNT_W'(1) : sel_base;
    sel_ack  = ack_valid && (ack_page == acc_page);
    fire     = acc_valid && (sel_new >= cfg_hot_thresh) &&
               !(pend_q[acc_page] && !sel_ack);
  end

  // per-page heat counter and pending bit
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    logic [CNT_W-1:0] base, cnt_d;
    logic             hit_pg, ack_pg, cnt_en;

    assign hit_pg = acc_valid && (acc_page == PAGE_W'(g));
    assign ack_pg = ack_valid && (ack_page == PAGE_W'(g));
    assign base   = decay ? (cnt_q[g] >> 1) : cnt_q[g];
    assign cnt_d  = (hit_pg && base != CNT_MAX) ? base + CNT_W'(1) : base;
    assign cnt_en = decay || hit_pg;
    assign pend_d[g] = (pend_q[g] && !ack_pg) || (fire && hit_pg);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[g] <= '0;
      else if (cnt_en) cnt_q[g] <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  logic              pv_q;
  logic [PAGE_W-1:0] pp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pp_q <= '0;
    end else begin
      pv_q <= fire;
      if (fire) pp_q <= acc_page;
    end
  end

  assign promo_valid = pv_q;
  assign promo_page  = pp_q;
endmodule

// File: rtl/hpm_flash_est.sv
module hpm_flash_est
  import hpm_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int LAT_W  = 20,
  parameter  int PAGE_W = 4,
  localparam int EST_W  = LAT_W + $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  cfg_rd_lat,
  input  logic [LAT_W-1:0]  cfg_wr_lat,
  input  logic [LAT_W-1:0]  cfg_cs_cost,
  input  logic              acc_valid,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic              acc_write,
  input  logic              acc_hit,
  input  logic              flash_done,
  output logic              hint_valid,
  output logic [PAGE_W-1:0] hint_page,
  output logic [EST_W-1:0]  hint_est
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int USE_W = $clog2(DEPTH + 1);
  localparam logic [USE_W-1:0] FULL = USE_W'(DEPTH);

  logic [LAT_W-1:0] lat_mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [USE_W-1:0] used_q, used_d;
  logic [LAT_W-1:0] head_q, head_d;
  logic [EST_W-1:0] tail_q, tail_d;

  flash_op_e        op;
  logic             miss, push, pop, raise;
  logic [LAT_W-1:0] new_lat, next_lat;
  logic [EST_W-1:0] est;

  always_comb begin
    op       = acc_write ? FOP_WRITE : FOP_READ;
    new_lat  = (op == FOP_WRITE) ? cfg_wr_lat : cfg_rd_lat;
    miss     = acc_valid && !acc_hit;
    est      = EST_W'(head_q) + tail_q + EST_W'(new_lat);
    raise    = miss && (est > EST_W'(cfg_cs_cost));
    push     = miss && (used_q != FULL);
    pop      = flash_done && (used_q != '0);
    next_lat = lat_mem[rd_q + PTR_W'(1)];

    head_d = (used_q != '0 && head_q != '0) ? head_q - LAT_W'(1) : head_q;
    tail_d = tail_q;
    if (pop) begin
      if (used_q >= USE_W'(2)) begin
        head_d = next_lat;
        tail_d = tail_q - EST_W'(next_lat) + (push ? EST_W'(new_lat) : '0);
      end else begin
        head_d = push ? new_lat : '0;
      end
    end else if (push) begin
      if (used_q == '0) head_d = new_lat;
      else              tail_d = tail_q + EST_W'(new_lat);
    end

    rd_d   = pop  ? rd_q + PTR_W'(1) : rd_q;
    wr_d   = push ? wr_q + PTR_W'(1) : wr_q;
    used_d = used_q + (push ? USE_W'(1) : '0) - (pop ? USE_W'(1) : '0);
  end

  always_ff @(posedge clk) begin
    if (push) lat_mem[wr_q] <= new_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wr_q   <= '0;
      used_q <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      used_q <= used_d;
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  logic              hv_q;
  logic [PAGE_W-1:0] hp_q;
  logic [EST_W-1:0]  he_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0;
      hp_q <= '0;
      he_q <= '0;
    end else begin
      hv_q <= raise;
      if (raise) begin
        hp_q <= acc_page;
        he_q <= est;
      end
    end
  end

  assign hint_valid = hv_q;
  assign hint_page  = hp_q;
  assign hint_est   = he_q;
endmodule

// File: rtl/hp_promo_hint.sv
module hp_promo_hint #(
  parameter  int NUM_PAGES = 16,
  parameter  int CNT_W     = 4,
  parameter  int EPOCH_W   = 16,
  parameter  int LAT_W     = 20,
  parameter  int Q_DEPTH   = 8,
  localparam int PAGE_W    = $clog2(NUM_PAGES),
  localparam int EST_W     = LAT_W + $clog2(Q_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_hot_thresh,
  input  logic [EPOCH_W-1:0] cfg_epoch_len,
  input  logic [LAT_W-1:0]   cfg_rd_lat,
  input  logic [LAT_W-1:0]   cfg_wr_lat,
  input  logic [LAT_W-1:0]   cfg_cs_cost,
  input  logic               acc_valid,
  input  logic [PAGE_W-1:0]  acc_page,
  input  logic               acc_write,
  input  logic               acc_hit,
  input  logic               flash_done,
  input  logic               promo_ack,
  input  logic [PAGE_W-1:0]  promo_ack_page,
  output logic               promo_valid,
  output logic [PAGE_W-1:0]  promo_page,
  output logic               hint_valid,
  output logic [PAGE_W-1:0]  hint_page,
  output logic [EST_W-1:0]   hint_est
);
  hpm_heat #(
    .NUM_PAGES(NUM_PAGES),
    .CNT_W    (CNT_W),
    .EPOCH_W  (EPOCH_W)
  ) u_heat (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_hot_thresh(cfg_hot_thresh),
    .cfg_epoch_len (cfg_epoch_len),
    .acc_valid     (acc_valid),
    .acc_page      (acc_page),
    .ack_valid     (promo_ack),
    .ack_page      (promo_ack_page),
    .promo_valid   (promo_valid),
    .promo_page    (promo_page)
  );

  hpm_flash_est #(
    .DEPTH (Q_DEPTH),
    .LAT_W (LAT_W),
    .PAGE_W(PAGE_W)
  ) u_est (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rd_lat (cfg_rd_lat),
    .cfg_wr_lat (cfg_wr_lat),
    .cfg_cs_cost(cfg_cs_cost),
    .acc_valid  (acc_valid),
    .acc_page   (acc_page),
    .acc_write  (acc_write),
    .acc_hit    (acc_hit),
    .flash_done (flash_done),
    .hint_valid (hint_valid),
    .hint_page  (hint_page),
    .hint_est   (hint_est)
  );
endmodule

// File: rtl/hpm_checker.sv
module hpm_checker #(
  parameter int PAGE_W = 4,
  parameter int LAT_W  = 20,
  parameter int EST_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LAT_W-1:0]  cfg_cs_cost,
  input logic              acc_valid,
  input logic [PAGE_W-1:0] acc_page,
  input logic              acc_hit,
  input logic              promo_valid,
  input logic [PAGE_W-1:0] promo_page,
  input logic              hint_valid,
  input logic [PAGE_W-1:0] hint_page,
  input logic [EST_W-1:0]  hint_est
);
  // R3: a promotion names the page accessed one cycle earlier
  a_r3_promo_from_access: assert property (@(posedge clk) disable iff (!rst_n)
    promo_valid |-> ($past(acc_valid) && promo_page == $past(acc_page)));

  // R6: a hint only follows a miss
  a_r6_hint_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    hint_valid |-> ($past(acc_valid) && !$past(acc_hit)));

  // R6: a hint carries an estimate above the switch cost
  a_r6_hint_over_cost: assert property (@(posedge clk) disable iff (!rst_n)
    hint_valid |-> (hint_est > EST_W'($past(cfg_cs_cost))));

  // R6: the hint page is the missing page
  a_r6_hint_page: assert property (@(posedge clk) disable iff (!rst_n)
    hint_valid |-> (hint_page == $past(acc_page)));

  // R7: a hit is followed by no hint
  a_r7_hit_no_hint: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |=> !hint_valid);
endmodule

bind hp_promo_hint hpm_checker #(
  .PAGE_W(PAGE_W),
  .LAT_W (LAT_W),
  .EST_W (EST_W)
) u_hpm_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_cs_cost(cfg_cs_cost),
  .acc_valid  (acc_valid),
  .acc_page   (acc_page),
  .acc_hit    (acc_hit),
  .promo_valid(promo_valid),
  .promo_page (promo_page),
  .hint_valid (hint_valid),
  .hint_page  (hint_page),
  .hint_est   (hint_est)
);

// File: tb/test_hp_promo_hint.sv
module test_hp_promo_hint;
  localparam int NP = 16, CW = 4, EW = 16, LW = 20, QD = 8;
  localparam int PW = 4, SW = 24, CMAX = 15;

  logic          clk, rst_n;
  logic [CW-1:0] cfg_hot_thresh;
  logic [EW-1:0] cfg_epoch_len;
  logic [LW-1:0] cfg_rd_lat, cfg_wr_lat, cfg_cs_cost;
  logic          acc_valid, acc_write, acc_hit, flash_done, promo_ack;
  logic [PW-1:0] acc_page, promo_ack_page;
  logic          promo_valid, hint_valid;
  logic [PW-1:0] promo_page, hint_page;
  logic [SW-1:0] hint_est;

  hp_promo_hint i_hp_promo_hint (
    .clk(clk), .rst_n(rst_n), .cfg_hot_thresh(cfg_hot_thresh),
    .cfg_epoch_len(cfg_epoch_len), .cfg_rd_lat(cfg_rd_lat),
    .cfg_wr_lat(cfg_wr_lat), .cfg_cs_cost(cfg_cs_cost),
    .acc_valid(acc_valid), .acc_page(acc_page), .acc_write(acc_write),
    .acc_hit(acc_hit), .flash_done(flash_done), .promo_ack(promo_ack),
    .promo_ack_page(promo_ack_page), .promo_valid(promo_valid),
    .promo_page(promo_page), .hint_valid(hint_valid),
    .hint_page(hint_page), .hint_est(hint_est)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string tag_p = "R3", tag_h = "R6";

  // reference model state
  int m_cnt [NP];
  bit m_pend [NP];
  int m_ep, m_head;
  int m_q [$];
  bit e_pv, e_hv;
  int e_pp, e_hp, e_he;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin m_cnt[p] = 0; m_pend[p] = 0; end
    m_ep = 0; m_head = 0; m_q.delete();
    e_pv = 0; e_hv = 0; e_pp = 0; e_hp = 0; e_he = 0;
  endtask

  function automatic int tail_sum();
    int s = 0;
    for (int i = 1; i < m_q.size(); i++) s += m_q[i];
    return s;
  endfunction

  task automatic model_step();
    int b [NP];
    bit dec, pe, fire, popped, pushed;
    int lat, est, used0, pg, kp;
    pg  = int'(acc_page);
    kp  = int'(promo_ack_page);
    dec = (cfg_epoch_len != 0) && (m_ep >= int'(cfg_epoch_len) - 1);
    m_ep = (dec || cfg_epoch_len == 0) ? 0 : m_ep + 1;
    for (int p = 0; p < NP; p++) b[p] = dec ? (m_cnt[p] >> 1) : m_cnt[p];
    if (acc_valid && b[pg] < CMAX) b[pg]++;
    pe   = m_pend[pg] && !(promo_ack && kp == pg);
    fire = acc_valid && (b[pg] >= int'(cfg_hot_thresh)) && !pe;
    if (promo_ack) m_pend[kp] = 0;
    if (fire) m_pend[pg] = 1;
    for (int p = 0; p < NP; p++) m_cnt[p] = b[p];
    e_pv = fire; if (fire) e_pp = pg;
    lat = acc_write ? int'(cfg_wr_lat) : int'(cfg_rd_lat);
    est = m_head + tail_sum() + lat;
    e_hv = acc_valid && !acc_hit && (est > int'(cfg_cs_cost));
    if (e_hv) begin e_hp = pg; e_he = est; end
    used0  = m_q.size();
    popped = flash_done && used0 > 0;
    pushed = acc_valid && !acc_hit && used0 < QD;
    if (popped) void'(m_q.pop_front());
    if (pushed) m_q.push_back(lat);
    if (popped) m_head = (m_q.size() > 0) ? m_q[0] : 0;
    else if (pushed && used0 == 0) m_head = lat;
    else if (used0 > 0 && m_head > 0) m_head--;
  endtask

  task automatic compare();
    chk(promo_valid == e_pv, tag_p, "promo_valid", promo_valid, e_pv);
    if (e_pv) chk(int'(promo_page) == e_pp, tag_p, "promo_page", promo_page, e_pp);
    chk(hint_valid == e_hv, tag_h, "hint_valid", hint_valid, e_hv);
    if (e_hv) begin
      chk(int'(hint_page) == e_hp, tag_h, "hint_page", hint_page, e_hp);
      chk(int'(hint_est) == e_he, tag_h, "hint_est", hint_est, e_he);
    end
  endtask

  // one cycle: drive at the falling edge, predict, compare at the next falling edge
  task automatic step(bit v, int pg, bit wr, bit hit, bit done, bit ak, int akp);
    acc_valid = v; acc_page = PW'(pg); acc_write = wr; acc_hit = hit;
    flash_done = done; promo_ack = ak; promo_ack_page = PW'(akp);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset(int th, int ep, int rd, int wr, int cs);
    rst_n = 1'b0;
    cfg_hot_thresh = CW'(th); cfg_epoch_len = EW'(ep);
    cfg_rd_lat = LW'(rd); cfg_wr_lat = LW'(wr); cfg_cs_cost = LW'(cs);
    acc_valid = 0; acc_page = '0; acc_write = 0; acc_hit = 0;
    flash_done = 0; promo_ack = 0; promo_ack_page = '0;
    repeat (3) @(negedge clk);
    chk(!promo_valid, "R1", "promo_valid in reset", promo_valid, 0);
    chk(!hint_valid, "R1", "hint_valid in reset", hint_valid, 0);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20251));
    @(negedge clk);

    // R1: quiet after reset, empty backlog on the first miss
    tag_p = "R1"; tag_h = "R1";
    do_reset(2, 0, 50, 200, 40);
    idle(2);
    step(1, 3, 0, 0, 0, 0, 0);
    chk(hint_valid && int'(hint_est) == 50, "R1", "first miss estimate", hint_est, 50);

    // R2, R3, R4: threshold, pending, ack, saturation
    tag_p = "R3"; tag_h = "R7";
    do_reset(3, 0, 10, 10, 1000);
    for (int i = 0; i < 3; i++) step(1, 5, 0, 1, 0, 0, 0);
    tag_p = "R4";
    for (int i = 0; i < 4; i++) step(1, 5, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 5);
    step(1, 5, 0, 1, 0, 0, 0);
    chk(promo_valid && promo_page == 4'd5, "R4", "repromote after ack", promo_valid, 1);
    step(1, 5, 0, 1, 0, 1, 5);
    chk(promo_valid, "R4", "ack with access in one cycle", promo_valid, 1);
    tag_p = "R2";
    cfg_hot_thresh = CW'(CMAX);
    for (int i = 0; i < 20; i++) step(1, 9, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 9);
    step(1, 9, 0, 1, 0, 0, 0);
    chk(promo_valid && promo_page == 4'd9, "R2", "saturated counter stays hot", promo_valid, 1);

    // R5: decay and access in the same cycle
    tag_p = "R5"; tag_h = "R5";
    do_reset(4, 20, 10, 10, 1000);
    for (int i = 0; i < 3; i++) step(1, 7, 0, 1, 0, 0, 0);
    idle(16);
    step(1, 7, 0, 1, 0, 0, 0);
    chk(!promo_valid, "R5", "halved before increment", promo_valid, 0);
    step(1, 7, 0, 1, 0, 0, 0);
    step(1, 7, 0, 1, 0, 0, 0);
    chk(promo_valid, "R5", "promotion after regaining heat", promo_valid, 0);
    idle(45);

    // R6, R7, R8: estimate, hits, full queue, completion with miss
    tag_p = "R3"; tag_h = "R6";
    do_reset(15, 0, 30, 90, 100);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 2, 1, 0, 0, 0, 0);
    chk(hint_valid && int'(hint_est) == 120, "R6", "backlog plus write", hint_est, 120);
    tag_h = "R8";
    for (int i = 0; i < 9; i++) step(1, 3, 1, 0, 0, 0, 0);
    step(1, 4, 0, 0, 1, 0, 0);
    step(1, 6, 1, 0, 1, 0, 0);
    tag_h = "R7";
    for (int i = 0; i < 4; i++) step(1, 8, 1, 1, 0, 0, 0);
    tag_h = "R8";
    for (int i = 0; i < 14; i++) begin step(0, 0, 0, 0, 1, 0, 0); idle(3); end
    step(1, 10, 0, 0, 1, 0, 0);
    idle(40);
    step(1, 11, 1, 0, 0, 0, 0);

    // random traffic
    tag_p = "R3"; tag_h = "R6";
    do_reset(2 + $urandom_range(0, 6), 50, 15, 80, 60);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 70, $urandom_range(0, 5), $urandom_range(0, 3) == 0,
           $urandom_range(0, 1), $urandom_range(0, 9) < 3,
           $urandom_range(0, 9) < 2, $urandom_range(0, 5));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not end actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule